// File: doc/BRIEF.md
# External Interrupt Edge Capture Unit

This block watches seven asynchronous interrupt lines on behalf of a small processor core. Every line passes through a two-stage synchronizer and then an edge detector whose direction is fixed or programmable, depending on the line. A qualifying edge sets that line's pending flag. Each line also has an enable bit. A flag counts toward a request only while its enable bit is 1.

Pending, enabled lines are presented to the core as a single request stream. `req_valid` is high while at least one enabled flag is pending, and `req_idx` names the lowest-numbered such line. The core accepts a request by raising `req_ready`. A transfer takes place on any clock edge where `req_valid` and `req_ready` are both high, and that transfer clears the flag of the line that `req_idx` named.

Back-pressure has these rules:
- While `req_ready` is low, no flag is cleared and the request stays up.
- A new edge on a lower-numbered enabled line can move `req_idx` to that line before acceptance, so the index is not frozen.
- `req_ready` has no effect while `req_valid` is low.

Enables and the polarity bits are written as whole words through plain strobes, and their current values are visible on read-back outputs.

Top module: `ext_irq_capture`

## Requirements
- R1: After reset, all flags, all enables and both polarity bits are 0, and `req_valid` is 0.
- R2: Lines 0, 1 and 4 set their flag on a 0→1 transition of `irq_in`, and a 1→0 transition sets nothing.
- R3: Lines 5 and 6 are inverted ahead of a rising-edge detector, so they set their flag on a 1→0 transition of `irq_in`, and a 0→1 transition sets nothing.
- R4: Line 2 uses `pol_q[0]` and line 3 uses `pol_q[1]`. A bit value of 0 selects falling-edge sensitivity and 1 selects rising. Changing a polarity bit while the input is steady sets no flag.
- R5: A change on `irq_in` that drives the input one half-cycle before clock edge E0 is visible on `flag_q` after edge E2 and not after edge E1.
- R6: A flag is set whether or not its line is enabled. `req_valid` is 1 only while some line has both its flag and its enable bit at 1.
- R7: `req_idx` is the lowest-numbered line whose flag and enable are both 1.
- R8: A transfer (`req_valid` and `req_ready` both high at a clock edge) clears the flag named by `req_idx` on that edge and leaves every other flag unchanged.
- R9: If a qualifying edge on a line arrives on the same clock edge as the transfer that would clear that line, the flag stays 1.
- R10: `req_ready` high while `req_valid` is low changes no flag.
- R11: `en_we` loads all seven enables from `en_wdata` (bit i is line i), and `pol_we` loads both polarity bits from `pol_wdata`, each on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| irq_in | input | 7 | Raw asynchronous interrupt lines, bit i is line i |
| en_we | input | 1 | Write strobe for the enable word |
| en_wdata | input | 7 | New enable word |
| pol_we | input | 1 | Write strobe for the polarity bits |
| pol_wdata | input | 2 | New polarity bits (bit 0 = line 2, bit 1 = line 3; 1 = rising) |
| req_valid | output | 1 | An enabled line is pending |
| req_ready | input | 1 | Core accepts the current request |
| req_idx | output | 3 | Lowest-numbered enabled pending line |
| en_q | output | 7 | Current enable word |
| pol_q | output | 2 | Current polarity bits |
| flag_q | output | 7 | Current pending flags |

## Verification
The two functions that can coincide are the setting of a flag by a fresh edge and its clearing by an accepted transfer to the same line. The bench provokes this by arming line 4 as pending, returning its input low, and then raising it again. It counts the two synchronizer edges so that `req_ready` is high exactly on the edge where the edge detector fires. The flag must still read 1 afterwards. A control run with the same ready pulse and no edge must leave the flag at 0, which shows that the transfer itself really took place.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int NUM_LINES = 7;
  localparam int IDX_W     = $clog2(NUM_LINES);
  localparam int NUM_PROG  = 2;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_PROG = 2'd2
  } edge_mode_e;

  function automatic edge_mode_e line_mode(input int line);
    case (line)
      2, 3:    return EDGE_PROG;
      5, 6:    return EDGE_FALL;
      default: return EDGE_RISE;
    endcase
  endfunction

  function automatic int prog_slot(input int line);
    return (line == 3) ? 1 : 0;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= async_in;
      stage2 <= stage1;
    end
  end

  assign sync_out = stage2;

  // R5: second stage follows the first by exactly one cycle
  a_r5_sync_shift: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> stage2 == $past(stage1));
endmodule

// File: rtl/irq_edge_cell.sv
module irq_edge_cell
  import ext_irq_pkg::*;
#(
  parameter edge_mode_e MODE = EDGE_RISE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic pol_rise,
  input  logic clr,
  output logic hit,
  output logic flag
);
  logic prev_q;
  logic rise_seen;
  logic fall_seen;

  assign rise_seen = sync_in & ~prev_q;
  assign fall_seen = ~sync_in & prev_q;

  generate
    if (MODE == EDGE_PROG) begin : g_prog
      assign hit = pol_rise ? rise_seen : fall_seen;
    end else if (MODE == EDGE_FALL) begin : g_inv
      logic inv_cur, inv_prev;
      assign inv_cur  = ~sync_in;
      assign inv_prev = ~prev_q;
      assign hit      = inv_cur & ~inv_prev;
    end else begin : g_rise
      assign hit = rise_seen;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag   <= 1'b0;
    end else begin
      prev_q <= sync_in;
      flag   <= hit | (flag & ~clr);
    end
  end

  // R9: a detected edge always leaves the flag set, even under a clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
  // R8: a clear without a coincident edge drops the flag
  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag);
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N     = 7,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     pend,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        valid = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  // R7: nothing below the reported index is pending
  a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((pend & ((N'(1) << idx) - N'(1))) == '0) && pend[idx]);
endmodule

// File: rtl/ext_irq_capture.sv
module ext_irq_capture
  import ext_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 en_we,
  input  logic [NUM_LINES-1:0] en_wdata,
  input  logic                 pol_we,
  input  logic [NUM_PROG-1:0]  pol_wdata,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic [IDX_W-1:0]     req_idx,
  output logic [NUM_LINES-1:0] en_q,
  output logic [NUM_PROG-1:0]  pol_q,
  output logic [NUM_LINES-1:0] flag_q
);
  logic [NUM_LINES-1:0] sync_lines;
  logic [NUM_LINES-1:0] hit;
  logic [NUM_LINES-1:0] clr;
  logic                 accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pol_q <= '0;
    end else begin
      if (en_we)  en_q  <= en_wdata;
      if (pol_we) pol_q <= pol_wdata;
    end
  end

  irq_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (irq_in),
    .sync_out (sync_lines)
  );

  assign accept = req_valid & req_ready;

  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      localparam edge_mode_e LM = line_mode(g);
      logic pol_sel;
      if (LM == EDGE_PROG) begin : g_pol
        assign pol_sel = pol_q[prog_slot(g)];
      end else begin : g_nopol
        assign pol_sel = 1'b0;
      end
      assign clr[g] = accept && (req_idx == IDX_W'(g));
      irq_edge_cell #(.MODE(LM)) u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (sync_lines[g]),
        .pol_rise (pol_sel),
        .clr      (clr[g]),
        .hit      (hit[g]),
        .flag     (flag_q[g])
      );
    end
  endgenerate

  irq_prio #(.N(NUM_LINES), .IDX_W(IDX_W)) u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (flag_q & en_q),
    .valid (req_valid),
    .idx   (req_idx)
  );

  // R10: without a transfer no flag ever falls
  a_r10_no_silent_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  // R6: a request implies an enabled pending line
  a_r6_valid_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (en_q[req_idx] && flag_q[req_idx]));
endmodule

// File: tb/ext_irq_capture_bench.sv
module ext_irq_capture_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] irq_in = '0;
  logic       en_we = 1'b0;
  logic [6:0] en_wdata = '0;
  logic       pol_we = 1'b0;
  logic [1:0] pol_wdata = '0;
  logic       req_ready = 1'b0;
  logic       req_valid;
  logic [2:0] req_idx;
  logic [6:0] en_q;
  logic [1:0] pol_q;
  logic [6:0] flag_q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ext_irq_capture u_ext_irq_capture (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .en_we(en_we), .en_wdata(en_wdata), .pol_we(pol_we), .pol_wdata(pol_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_idx(req_idx),
    .en_q(en_q), .pol_q(pol_q), .flag_q(flag_q)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_pin(input int line, input logic v);
    irq_in[line] = v;
    cyc(4);
  endtask

  task automatic write_en(input logic [6:0] v);
    en_we = 1'b1; en_wdata = v;
    cyc(1);
    en_we = 1'b0;
  endtask

  task automatic write_pol(input logic [1:0] v);
    pol_we = 1'b1; pol_wdata = v;
    cyc(1);
    pol_we = 1'b0;
  endtask

  task automatic clear_all();
    write_en(7'h7f);
    req_ready = 1'b1;
    repeat (8) cyc(1);
    req_ready = 1'b0;
    write_en(7'h00);
  endtask

  task automatic t_reset();
    chk("R1", "flags", flag_q, 0);
    chk("R1", "enables", en_q, 0);
    chk("R1", "polarity", pol_q, 0);
    chk("R1", "valid", req_valid, 0);
  endtask

  task automatic t_writes();
    write_en(7'h55);
    chk("R11", "enable load", en_q, 7'h55);
    write_pol(2'b10);
    chk("R11", "polarity load", pol_q, 2);
    write_pol(2'b00);
    write_en(7'h00);
    chk("R11", "enable reload", en_q, 0);
  endtask

  task automatic t_rising_lines();
    clear_all();
    set_pin(0, 1); set_pin(1, 1); set_pin(4, 1);
    chk("R2", "rise sets 0,1,4", flag_q, 7'h13);
    clear_all();
    set_pin(0, 0); set_pin(1, 0); set_pin(4, 0);
    chk("R2", "fall ignored 0,1,4", flag_q, 0);
  endtask

  task automatic t_falling_lines();
    clear_all();
    set_pin(5, 1); set_pin(6, 1);
    chk("R3", "rise ignored 5,6", flag_q, 0);
    set_pin(5, 0); set_pin(6, 0);
    chk("R3", "fall sets 5,6", flag_q, 7'h60);
    clear_all();
  endtask

  task automatic t_prog_lines();
    clear_all();
    set_pin(2, 1); set_pin(3, 1);
    chk("R4", "pol0 rise ignored", flag_q, 0);
    write_pol(2'b11); cyc(3);
    chk("R4", "pol change steady", flag_q, 0);
    set_pin(2, 0); set_pin(3, 0);
    chk("R4", "pol1 fall ignored", flag_q, 0);
    set_pin(2, 1);
    chk("R4", "pol1 rise sets 2", flag_q, 7'h04);
    write_pol(2'b00);
    set_pin(3, 1); set_pin(3, 0);
    chk("R4", "pol0 fall sets 3", flag_q, 7'h0c);
    set_pin(2, 0);
    clear_all();
  endtask

  task automatic t_latency();
    clear_all();
    irq_in[1] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R5", "not yet after E1", flag_q[1], 0);
    @(posedge clk); @(negedge clk);
    chk("R5", "set after E2", flag_q[1], 1);
    set_pin(1, 0);
    clear_all();
  endtask

  task automatic t_enable_gating();
    clear_all();
    set_pin(0, 1);
    chk("R6", "flag while disabled", flag_q[0], 1);
    chk("R6", "no valid while disabled", req_valid, 0);
    write_en(7'h02);
    chk("R6", "other enable no valid", req_valid, 0);
    write_en(7'h01);
    chk("R6", "valid once enabled", req_valid, 1);
    set_pin(0, 0);
    clear_all();
  endtask

  task automatic t_priority();
    clear_all();
    set_pin(1, 1); set_pin(4, 1);
    set_pin(6, 1); set_pin(6, 0);
    write_en(7'h50);
    chk("R7", "idx among 4,6", req_idx, 4);
    write_en(7'h7f);
    chk("R7", "idx among 1,4,6", req_idx, 1);
    write_en(7'h40);
    chk("R7", "idx only 6", req_idx, 6);
    set_pin(1, 0); set_pin(4, 0);
    clear_all();
  endtask

  task automatic t_accept();
    clear_all();
    set_pin(0, 1); set_pin(4, 1);
    write_en(7'h7f);
    chk("R8", "idx before accept", req_idx, 0);
    req_ready = 1'b1; cyc(1); req_ready = 1'b0;
    chk("R8", "flags after accept", flag_q, 7'h10);
    chk("R8", "idx moves", req_idx, 4);
    set_pin(0, 0); set_pin(4, 0);
    clear_all();
  endtask

  task automatic t_ready_idle();
    clear_all();
    set_pin(1, 1);
    req_ready = 1'b1; cyc(3); req_ready = 1'b0;
    chk("R10", "ready while idle", flag_q, 7'h02);
    set_pin(1, 0);
    clear_all();
  endtask

  task automatic t_set_wins();
    clear_all();
    set_pin(4, 1); set_pin(4, 0);
    write_en(7'h10);
    chk("R9", "armed", req_valid, 1);
    irq_in[4] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    chk("R9", "set beats clear", flag_q[4], 1);
    req_ready = 1'b1; cyc(1); req_ready = 1'b0;
    chk("R9", "plain clear", flag_q[4], 0);
    set_pin(4, 0);
    clear_all();
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_writes();
    t_rising_lines();
    t_falling_lines();
    t_prog_lines();
    t_latency();
    t_enable_gating();
    t_priority();
    t_accept();
    t_ready_idle();
    t_set_wins();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired: actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule